// File: doc/BRIEF.md
# Banked Level Interrupt Combiner

The combiner gathers a large set of level-sensitive interrupt lines into one output per group of eight lines, so that a parent interrupt controller only has to watch a handful of inputs. A group output is high while at least one of its lines is both high and enabled. Groups are counted from zero. Source line `j` of group `n` has the flat index `8*n + j` on the `src_lvl` input.

Software reaches the enable state through a small register interface. Four groups share one 32-bit bank. Bank `k` starts at byte address `0x10*k`. Group `n` sits in bank `n/4` and uses bits `8*(n%4)` to `8*(n%4)+7` of every register in that bank. Within a bank there are three registers. The set register (offset 0x0) turns on the enables marked by one bits. The clear register (offset 0x4) turns off the enables marked by one bits. The status register (offset 0xC) reports the pending lines. Since each register only acts on one bits, software can mask one line or a whole group without a read-modify-write. The number of groups is a parameter.

Top module: `irq_combiner_top`

## Requirements
- R1: During and after reset every enable bit is 0, every bit of `grp_irq` is 0 and `bus_rdata` is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1. Bits written as 0 leave their enables unchanged. This is the only way an enable bit falls outside reset.
- R4: A read of bank offset 0x0 or 0x4 returns that bank's current enable mask. Read data appears on `bus_rdata` on the clock edge after the read strobe and holds until the next read.
- R5: A read of bank offset 0xC returns, for each bit, the source level ANDed with its enable bit, as sampled on the read edge.
- R6: Bank `k` decodes at address `0x10*k` (address bits [3:0] select the register). Group `n` occupies bits `8*(n%4)+7 : 8*(n%4)` of bank `n/4`. Writes to one bank leave every other bank unchanged.
- R7: `grp_irq[n]` is the OR of the eight enabled source levels of group `n`. It is registered, so a change of source level is seen on `grp_irq` one clock edge later.
- R8: Writing `0xFF << 8*(n%4)` to the clear register of bank `n/4` disables all eight lines of group `n`. No other group is affected.
- R9: Writes to any other offset (0x8 or any unaligned one), or to a bank index at or beyond the number of banks, change nothing. Reads of them return 0.
- R10: When an enable write and a source change reach the same clock edge, `grp_irq` after that edge already reflects both the new enable and the new source level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: bits [ADDR_W-1:4] select the bank, bits [3:0] the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | NUM_GROUPS*8 | Level-sensitive source lines, flat index 8*group+line |
| grp_irq | output | NUM_GROUPS | One registered interrupt output per group |

## Verification
The delicate case is an enable write that lands on the same clock edge as a change of source level. The output register is fed from the next-state enables, so both changes must appear together after a single edge. The bench provokes this by driving a set-register write and a new source pattern in the same cycle. It then checks `grp_irq` right after that one edge. A group disable through the clear register is applied while its lines are pending, and the output is expected to drop after one edge, not two.

// File: rtl/comb_pkg.sv
package comb_pkg;
  localparam int LINES_PER_GRP = 8;
  localparam int GRP_PER_BANK  = 4;
  localparam int BANK_W        = LINES_PER_GRP * GRP_PER_BANK;
  localparam logic [3:0] OFF_SET  = 4'h0;
  localparam logic [3:0] OFF_CLR  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'hC;
endpackage

// File: rtl/comb_enable_bank.sv
module comb_enable_bank #(
  parameter int GRPS = 4,
  localparam int W = GRPS * comb_pkg::LINES_PER_GRP
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       do_set,
  input  logic                       do_clr,
  input  logic [comb_pkg::BANK_W-1:0] wdata,
  output logic [W-1:0]               en_q,
  output logic [W-1:0]               en_next
);
  always_comb begin
    en_next = en_q;
    if (do_set) en_next = en_q | wdata[W-1:0];
    if (do_clr) en_next = en_q & ~wdata[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_next;
  end
endmodule

// File: rtl/comb_group_out.sv
module comb_group_out (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [comb_pkg::LINES_PER_GRP-1:0]  src,
  input  logic [comb_pkg::LINES_PER_GRP-1:0]  en,
  output logic                                irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(src & en);
  end
endmodule

// File: rtl/comb_read_mux.sv
module comb_read_mux #(
  parameter int NUM_BANKS = 2,
  parameter int BIDX_W    = 4,
  localparam int PAD_W    = NUM_BANKS * comb_pkg::BANK_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_stb,
  input  logic [BIDX_W-1:0]           bank_idx,
  input  logic [3:0]                  offset,
  input  logic [PAD_W-1:0]            en_pad,
  input  logic [PAD_W-1:0]            stat_pad,
  output logic [comb_pkg::BANK_W-1:0] rdata_q
);
  import comb_pkg::*;
  logic [BANK_W-1:0] sel_en, sel_stat, rd_val;

  always_comb begin
    sel_en   = '0;
    sel_stat = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == BIDX_W'(b)) begin
        sel_en   = en_pad[b*BANK_W +: BANK_W];
        sel_stat = stat_pad[b*BANK_W +: BANK_W];
      end
    end
    case (offset)
      OFF_SET, OFF_CLR: rd_val = sel_en;
      OFF_STAT:         rd_val = sel_stat;
      default:          rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_val;
  end
endmodule

// File: rtl/irq_combiner_top.sv
module irq_combiner_top #(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8,
  localparam int NUM_SRC   = NUM_GROUPS * comb_pkg::LINES_PER_GRP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_SRC-1:0]    src_lvl,
  output logic [NUM_GROUPS-1:0] grp_irq
);
  import comb_pkg::*;
  localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK;
  localparam int BIDX_W    = ADDR_W - 4;
  localparam int PAD_W     = NUM_BANKS * BANK_W;

  logic [BIDX_W-1:0]  bank_idx;
  logic [3:0]         offset;
  logic               wr_set, wr_clr;
  logic [NUM_SRC-1:0] en_state, en_next;
  logic [PAD_W-1:0]   en_pad, stat_pad;

  assign bank_idx = bus_addr[ADDR_W-1:4];
  assign offset   = bus_addr[3:0];
  assign wr_set   = bus_sel && bus_wr && (offset == OFF_SET);
  assign wr_clr   = bus_sel && bus_wr && (offset == OFF_CLR);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int G_HERE = (NUM_GROUPS - b*GRP_PER_BANK >= GRP_PER_BANK) ?
                            GRP_PER_BANK : NUM_GROUPS - b*GRP_PER_BANK;
    localparam int W_HERE = G_HERE * LINES_PER_GRP;
    logic hit;
    assign hit = (bank_idx == BIDX_W'(b));

    comb_enable_bank #(.GRPS(G_HERE)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .do_set  (wr_set && hit),
      .do_clr  (wr_clr && hit),
      .wdata   (bus_wdata),
      .en_q    (en_state[b*BANK_W +: W_HERE]),
      .en_next (en_next[b*BANK_W +: W_HERE])
    );

    assign en_pad[b*BANK_W +: W_HERE]   = en_state[b*BANK_W +: W_HERE];
    assign stat_pad[b*BANK_W +: W_HERE] = en_state[b*BANK_W +: W_HERE] &
                                          src_lvl[b*BANK_W +: W_HERE];
    if (W_HERE < BANK_W) begin : g_pad
      assign en_pad[b*BANK_W + W_HERE +: BANK_W - W_HERE]   = '0;
      assign stat_pad[b*BANK_W + W_HERE +: BANK_W - W_HERE] = '0;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    comb_group_out u_out (
      .clk   (clk),
      .rst   (rst),
      .src   (src_lvl[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .en    (en_next[g*LINES_PER_GRP +: LINES_PER_GRP]),
      .irq_q (grp_irq[g])
    );
  end

  comb_read_mux #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (bus_sel && !bus_wr),
    .bank_idx (bank_idx),
    .offset   (offset),
    .en_pad   (en_pad),
    .stat_pad (stat_pad),
    .rdata_q  (bus_rdata)
  );
endmodule

// File: rtl/comb_checker.sv
module comb_checker #(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8,
  localparam int NUM_SRC   = NUM_GROUPS * 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata,
  input logic [NUM_SRC-1:0]    src_lvl,
  input logic [NUM_GROUPS-1:0] grp_irq,
  input logic [NUM_SRC-1:0]    en_state
);
  logic was_rst = 1'b0;
  logic set_wr, clr_wr, odd_rd;
  assign set_wr = bus_sel && bus_wr && (bus_addr[3:0] == 4'h0);
  assign clr_wr = bus_sel && bus_wr && (bus_addr[3:0] == 4'h4);
  assign odd_rd = bus_sel && !bus_wr && (bus_addr[3:0] == 4'h8);

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (was_rst) begin
      assert_reset_clears_R1: assert (grp_irq == '0 && bus_rdata == '0 && en_state == '0);
    end
  end

  assert_rise_needs_set_R2: assert property (@(posedge clk) disable iff (rst)
    !set_wr |=> ((en_state & ~$past(en_state)) == '0));

  assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((~en_state & $past(en_state)) == '0));

  assert_unused_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    odd_rd |=> (bus_rdata == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_irq_needs_source_R7: assert property (@(posedge clk) disable iff (rst)
      grp_irq[g] |-> $past(|src_lvl[g*8 +: 8]));
  end
endmodule

bind irq_combiner_top comb_checker #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .src_lvl(src_lvl), .grp_irq(grp_irq), .en_state(en_state)
);

// File: tb/test_irq_combiner_top.sv
`timescale 1ns/1ps
module test_irq_combiner_top;
  localparam int NG = 8;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic [NS-1:0] src_lvl = '0;
  logic [NG-1:0] grp_irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_combiner_top #(.NUM_GROUPS(NG), .ADDR_W(8)) i_irq_combiner_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl), .grp_irq(grp_irq)
  );

  // op: 0 write, 1 read and compare, 2 drive src[31:0], 3 drive src[63:32]
  typedef struct packed { logic [1:0] op; logic [7:0] addr; logic [31:0] data; } vec_t;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 32'h0000_00F0},  // R2 set lines 4..7 of group 0
    '{2'd1, 8'h00, 32'h0000_00F0},  // R4
    '{2'd0, 8'h00, 32'h0000_0301},  // R2 zeros keep earlier bits
    '{2'd1, 8'h04, 32'h0000_03F1},  // R4 read through clear offset
    '{2'd0, 8'h04, 32'h0000_0030},  // R3 clear lines 4,5
    '{2'd1, 8'h00, 32'h0000_03C1},  // R3
    '{2'd0, 8'h10, 32'hFF00_0000},  // R6 group 7 in bank 1
    '{2'd1, 8'h10, 32'hFF00_0000},  // R6
    '{2'd1, 8'h00, 32'h0000_03C1},  // R6 bank 0 untouched
    '{2'd2, 8'h00, 32'hFFFF_FFFF},
    '{2'd1, 8'h0C, 32'h0000_03C1},  // R5 status = src & en
    '{2'd3, 8'h00, 32'h8000_0001},
    '{2'd1, 8'h1C, 32'h8000_0000},  // R5 bank 1 status
    '{2'd0, 8'h08, 32'hFFFF_FFFF},  // R9 unused offset write
    '{2'd1, 8'h00, 32'h0000_03C1},  // R9 no effect
    '{2'd1, 8'h08, 32'h0000_0000},  // R9 reads zero
    '{2'd1, 8'h02, 32'h0000_0000},  // R9 unaligned reads zero
    '{2'd0, 8'h20, 32'hFFFF_FFFF},  // R9 bank beyond range
    '{2'd1, 8'h20, 32'h0000_0000},  // R9
    '{2'd0, 8'h04, 32'h0000_FF00},  // R8 whole group 1 off
    '{2'd1, 8'h00, 32'h0000_00C1},  // R8 groups 0 kept
    '{2'd1, 8'h10, 32'hFF00_0000}   // R8 other bank kept
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R1 grp_irq in reset", 64'(grp_irq), 64'h0);
    check("R1 rdata in reset", 64'(bus_rdata), 64'h0);
    rst = 1'b0;
    bus_read(8'h00, rd);
    check("R1 enables after reset", 64'(rd), 64'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: bus_write(VEC[i].addr, VEC[i].data);
        2'd1: begin
          bus_read(VEC[i].addr, rd);
          check($sformatf("table entry %0d", i), 64'(rd), 64'(VEC[i].data));
        end
        2'd2: src_lvl[31:0] = VEC[i].data;
        default: src_lvl[63:32] = VEC[i].data;
      endcase
    end

    // en bank0 = 0xC1 (group 0), bank1 = group 7; src group0 and group7 pending
    @(negedge clk);
    check("R7 group outputs", 64'(grp_irq), 64'h81);

    // R7 one-edge latency on source drop
    src_lvl[63] = 1'b0;
    check("R7 before edge", 64'(grp_irq), 64'h81);
    @(negedge clk);
    check("R7 after one edge", 64'(grp_irq), 64'h01);
    src_lvl[63] = 1'b1;
    @(negedge clk);

    // R8 with pending lines: group 0 output drops after one edge
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_00FF;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R8 group 0 off after one edge", 64'(grp_irq), 64'h80);

    // R10 enable write and source change on the same edge
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0000;
    src_lvl[31:0] = 32'h0001_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R10 same-edge enable and source", 64'(grp_irq), 64'h84);

    // R8 whole group 7 off through bank 1 clear
    bus_write(8'h14, 32'hFF00_0000);
    check("R8 group 7 off", 64'(grp_irq), 64'h04);
    bus_read(8'h10, rd);
    check("R8 bank 1 mask empty", 64'(rd), 64'h0);

    // R1 reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 grp_irq after reset", 64'(grp_irq), 64'h0);
    rst = 1'b0;
    bus_read(8'h00, rd);
    check("R1 enables cleared", 64'(rd), 64'h0);
    @(negedge clk);
    check("R1 output stays low", 64'(grp_irq), 64'h0);

    finish_run();
  end
endmodule